// File: doc/BRIEF.md
# Wrapping Burst Line Memory Slave

This block is a synchronous slave on a parallel master bus that fronts a small internal word memory. It serves single-word transfers and line bursts. A line holds 16 bytes, which is four 32-bit words. A burst begins at the word the master asks for first, which is the critical word. The slave then steps its own copy of the word index, wrapping inside the line, so the master only has to present the address once.

The master opens a transfer with a one-cycle start strobe. A burst flag travels with the strobe. During the data phase the master drives a "more beats follow" signal, which the slave samples on every acknowledge edge. The slave can add between zero and three wait cycles in front of every acknowledge. A configuration input can make the slave decline bursts. When it declines, it raises the refuse output together with the first acknowledge and handles only that one word.

Top module: `burst_line_slave`

## Requirements
- R1: While reset is held and after it is released, `xfer_ack_o` and `burst_refuse_o` are low. Every memory word reads as zero until it is written.
- R2: A start strobe with `burst_req_i` low is a single transfer. It gets exactly one acknowledge, at the word given by byte-address bits [7:2].
- R3: On the start edge the slave latches the address. The first beat of a burst uses word index `addr_i[3:2]` inside the line given by `addr_i[7:4]`. Bits [1:0] are ignored, and changes on `addr_i` after the start edge have no effect.
- R4: Each later beat of a burst uses the previous index plus one, modulo 4. The line stays the same, so index 3 is followed by index 0.
- R5: A burst ends after the acknowledged beat on whose edge `more_beats_i` is low. It also ends after its fourth beat whatever `more_beats_i` shows. After the last beat `xfer_ack_o` stays low until a new start.
- R6: The value N on `cfg_wait_i` is sampled at the start edge. Every beat is then preceded by exactly N cycles with `xfer_ack_o` low. With N = 0 the first acknowledge comes in the cycle right after the start edge, and later beats follow back to back.
- R7: If `cfg_refuse_burst_i` is high at the start of a burst, the slave raises `burst_refuse_o` together with the first and only acknowledge. `burst_refuse_o` is never high at any other time.
- R8: On a read, `rdata_o` carries the addressed word during the acknowledge cycle. On a write, `wdata_i` is stored into the addressed word on the edge where `xfer_ack_o` is high.
- R9: A start strobe sampled while a transfer is still in progress is ignored, including one that arrives in the cycle of the last acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start_i | input | 1 | One-cycle transfer start strobe |
| burst_req_i | input | 1 | Burst flag, sampled with the start strobe |
| more_beats_i | input | 1 | High: another beat follows the current one |
| write_i | input | 1 | 1 = write, 0 = read, sampled at start |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data for the current beat |
| cfg_refuse_burst_i | input | 1 | Decline bursts |
| cfg_wait_i | input | 2 | Wait cycles inserted before each acknowledge |
| rdata_o | output | 32 | Read data, valid when acknowledging a read |
| xfer_ack_o | output | 1 | Beat acknowledge |
| burst_refuse_o | output | 1 | Burst refused, raised with the first acknowledge |

## Verification
Two things can fall in the same cycle: the final acknowledge of a transfer, and a new start strobe from the master. The bench provokes this by raising the strobe during the last acknowledge of a burst. It then checks that no further acknowledge appears and that the following transfer sees memory unchanged. The cap of four beats and a low `more_beats_i` can also meet on one edge. Random bursts keep `more_beats_i` high on the fourth beat and expect the burst to stop there anyway.

// File: rtl/burst_slave_pkg.sv
package burst_slave_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BEAT = 1'b1
   } slv_state_e;

endpackage

// File: rtl/bs_wrap_index.sv
module bs_wrap_index #(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [IDX_W-1:0] crit_i,
   input  logic             step_i,
   output logic [IDX_W-1:0] idx_o
);

   generate
      if (IDX_W < 1) begin : g_bad_idx
         $error("IDX_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_o <= '0;
      end else if (load_i) begin
         idx_o <= crit_i;
      end else if (step_i) begin
         idx_o <= idx_o + 1'b1;
      end
   end

   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> idx_o == $past(crit_i));                                     // R3
   AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> idx_o == IDX_W'($past(idx_o) + 1'b1));          // R4

endmodule

// File: rtl/bs_wait_timer.sv
module bs_wait_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] value_i,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= value_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done_o = (cnt_q == '0);

   AST_WAIT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));     // R6

endmodule

// File: rtl/bs_word_mem.sv
module bs_word_mem #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 64,
   parameter int AW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem_q [WORDS];

   generate
      if ((1 << AW) != WORDS) begin : g_bad_depth
         $error("WORDS must equal 2**AW");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) begin
            mem_q[i] <= '0;
         end
      end else if (we_i) begin
         mem_q[addr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem_q[addr_i];

   AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));                       // R8

endmodule

// File: rtl/burst_line_slave.sv
module burst_line_slave #(
   parameter int DATA_W     = 32,
   parameter int MEM_WORDS  = 64,
   parameter int LINE_BYTES = 16,
   parameter int WAIT_W     = 2
) (
   input  logic                                                    clk,
   input  logic                                                    rst_n,
   input  logic                                                    xfer_start_i,
   input  logic                                                    burst_req_i,
   input  logic                                                    more_beats_i,
   input  logic                                                    write_i,
   input  logic [$clog2(MEM_WORDS)+$clog2(DATA_W/8)-1:0]           addr_i,
   input  logic [DATA_W-1:0]                                       wdata_i,
   input  logic                                                    cfg_refuse_burst_i,
   input  logic [WAIT_W-1:0]                                       cfg_wait_i,
   output logic [DATA_W-1:0]                                       rdata_o,
   output logic                                                    xfer_ack_o,
   output logic                                                    burst_refuse_o
);
   import burst_slave_pkg::*;

   localparam int BYTES_W    = DATA_W / 8;
   localparam int BYTE_OFS   = $clog2(BYTES_W);
   localparam int LINE_WORDS = LINE_BYTES / BYTES_W;
   localparam int IDX_W      = $clog2(LINE_WORDS);
   localparam int WADDR_W    = $clog2(MEM_WORDS);
   localparam int LINE_W     = WADDR_W - IDX_W;

   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("DATA_W must be a multiple of 8 and at least 16");
      end
      if (LINE_WORDS < 2 || (1 << IDX_W) != LINE_WORDS) begin : g_bad_line
         $error("LINE_BYTES must hold a power-of-two count of at least two words");
      end
      if (MEM_WORDS < 2 * LINE_WORDS) begin : g_bad_mem
         $error("MEM_WORDS must cover at least two lines");
      end
   endgenerate

   slv_state_e        state_q;
   logic              burst_q;
   logic              refuse_q;
   logic              write_q;
   logic [LINE_W-1:0] line_q;
   logic [WAIT_W-1:0] wait_q;
   logic [IDX_W-1:0]  beat_q;
   logic [IDX_W-1:0]  idx;
   logic              busy;
   logic              start_take;
   logic              timer_done;
   logic              ack;
   logic              last_beat;
   logic              step;
   logic              timer_load;
   logic [WAIT_W-1:0] timer_value;
   logic [DATA_W-1:0] mem_rd;
   logic              unused_lo_bits;

   assign unused_lo_bits = ^addr_i[BYTE_OFS-1:0];

   assign busy        = (state_q == ST_BEAT);
   assign start_take  = xfer_start_i && !busy;
   assign ack         = busy && timer_done;
   assign last_beat   = !burst_q || !more_beats_i || (beat_q == IDX_W'(LINE_WORDS - 1));
   assign step        = ack && !last_beat;
   assign timer_load  = start_take || step;
   assign timer_value = start_take ? cfg_wait_i : wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         burst_q  <= 1'b0;
         refuse_q <= 1'b0;
         write_q  <= 1'b0;
         line_q   <= '0;
         wait_q   <= '0;
         beat_q   <= '0;
      end else if (start_take) begin
         state_q  <= ST_BEAT;
         burst_q  <= burst_req_i && !cfg_refuse_burst_i;
         refuse_q <= burst_req_i && cfg_refuse_burst_i;
         write_q  <= write_i;
         line_q   <= addr_i[BYTE_OFS+IDX_W +: LINE_W];
         wait_q   <= cfg_wait_i;
         beat_q   <= '0;
      end else if (ack) begin
         if (last_beat) begin
            state_q <= ST_IDLE;
         end else begin
            beat_q  <= beat_q + 1'b1;
         end
      end
   end

   bs_wrap_index #(.IDX_W(IDX_W)) idx_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_take),
      .crit_i (addr_i[BYTE_OFS +: IDX_W]),
      .step_i (step),
      .idx_o  (idx)
   );

   bs_wait_timer #(.CNT_W(WAIT_W)) wait_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (timer_load),
      .value_i (timer_value),
      .done_o  (timer_done)
   );

   bs_word_mem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS), .AW(WADDR_W)) mem_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ack && write_q),
      .addr_i  ({line_q, idx}),
      .wdata_i (wdata_i),
      .rdata_o (mem_rd)
   );

   assign xfer_ack_o     = ack;
   assign burst_refuse_o = ack && refuse_q;
   assign rdata_o        = (ack && !write_q) ? mem_rd : '0;

   AST_REFUSE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      burst_refuse_o |-> (xfer_ack_o && beat_q == '0));                       // R7
   AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ack_o && last_beat) |=> !xfer_ack_o);                             // R5
   AST_WAIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ack_o && !last_beat && wait_q != '0) |=> !xfer_ack_o);            // R6
   AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(line_q));                             // R3
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && xfer_start_i) |=> ($stable(write_q) && $stable(wait_q)));      // R9

endmodule

// File: tb/burst_line_slave_tb_top.sv
module burst_line_slave_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WORDS      = 64;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        xfer_start_i;
   logic        burst_req_i;
   logic        more_beats_i;
   logic        write_i;
   logic [7:0]  addr_i;
   logic [31:0] wdata_i;
   logic        cfg_refuse_burst_i;
   logic [1:0]  cfg_wait_i;
   logic [31:0] rdata_o;
   logic        xfer_ack_o;
   logic        burst_refuse_o;

   logic [31:0] model [WORDS];
   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_line_slave dut_i (
      .clk                (clk),
      .rst_n              (rst_n),
      .xfer_start_i       (xfer_start_i),
      .burst_req_i        (burst_req_i),
      .more_beats_i       (more_beats_i),
      .write_i            (write_i),
      .addr_i             (addr_i),
      .wdata_i            (wdata_i),
      .cfg_refuse_burst_i (cfg_refuse_burst_i),
      .cfg_wait_i         (cfg_wait_i),
      .rdata_o            (rdata_o),
      .xfer_ack_o         (xfer_ack_o),
      .burst_refuse_o     (burst_refuse_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_word(input logic [7:0] a, input int beat);
      return {a[7:4], 2'(a[3:2] + beat)};
   endfunction

   function automatic int exp_beats(input bit bst, input bit refuse, input int nb);
      return (bst && !refuse) ? nb : 1;
   endfunction

   task automatic run_xfer(input bit wr, input bit bst, input logic [7:0] a, input int nb,
                           input logic [1:0] w, input bit refuse, input bit poke_last);
      int beats = exp_beats(bst, refuse, nb);
      @(negedge clk);
      xfer_start_i       = 1'b1;
      burst_req_i        = bst;
      write_i            = wr;
      addr_i             = a;
      cfg_wait_i         = w;
      cfg_refuse_burst_i = refuse;
      more_beats_i       = bst;
      @(posedge clk);
      for (int b = 0; b < beats; b++) begin
         int wa = exp_word(a, b);
         for (int k = 0; k < int'(w); k++) begin
            @(negedge clk);
            xfer_start_i       = 1'b0;
            addr_i             = 8'($urandom);
            cfg_wait_i         = 2'($urandom);
            cfg_refuse_burst_i = 1'($urandom);
            chk(xfer_ack_o == 1'b0, "R6 ack low in wait", 32'(xfer_ack_o), 32'd0);
            @(posedge clk);
         end
         @(negedge clk);
         addr_i = 8'($urandom);
         if (poke_last && b == beats - 1) begin
            xfer_start_i = 1'b1;
            burst_req_i  = 1'($urandom);
            write_i      = 1'b1;
         end else begin
            xfer_start_i = 1'b0;
         end
         chk(xfer_ack_o == 1'b1, "R2/R6 beat ack", 32'(xfer_ack_o), 32'd1);
         chk(burst_refuse_o == (bst && refuse && b == 0), "R7 refuse flag",
             32'(burst_refuse_o), 32'(bst && refuse && b == 0));
         if (!wr)
            chk(rdata_o == model[wa], "R3/R4/R8 read word", rdata_o, model[wa]);
         wdata_i = $urandom;
         if (!bst || refuse) more_beats_i = 1'($urandom) | refuse;
         else                more_beats_i = (b < nb - 1) || (b == 3);
         @(posedge clk);
         if (wr) model[wa] = wdata_i;
      end
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         xfer_start_i = 1'b0;
         chk(xfer_ack_o == 1'b0, poke_last ? "R9 start ignored" : "R5 burst ended",
             32'(xfer_ack_o), 32'd0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0;
      xfer_start_i = 1'b0; burst_req_i = 1'b0; more_beats_i = 1'b0; write_i = 1'b0;
      addr_i = '0; wdata_i = '0; cfg_refuse_burst_i = 1'b0; cfg_wait_i = '0;
      for (int i = 0; i < WORDS; i++) model[i] = '0;
      repeat (3) begin
         @(negedge clk);
         chk(xfer_ack_o == 1'b0 && burst_refuse_o == 1'b0, "R1 reset quiet",
             {30'd0, xfer_ack_o, burst_refuse_o}, 32'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(xfer_ack_o == 1'b0, "R1 quiet after reset", 32'(xfer_ack_o), 32'd0);

      // R1: untouched words read zero; R2 single read
      run_xfer(1'b0, 1'b0, 8'h25, 1, 2'd0, 1'b0, 1'b0);
      // R2/R8: single writes fill memory, low address bits random
      for (int i = 0; i < WORDS; i++)
         run_xfer(1'b1, 1'b0, 8'((i << 2) | ($urandom & 3)), 1, 2'($urandom), 1'b0, 1'b0);
      // R3/R4: full burst from each critical word, back-to-back beats
      for (int c = 0; c < 4; c++)
         run_xfer(1'b0, 1'b1, 8'(8'h50 | (c << 2)), 4, 2'd0, 1'b0, 1'b0);
      // R5: early end after two beats, wrapping past index 3
      run_xfer(1'b0, 1'b1, 8'h3C, 2, 2'd1, 1'b0, 1'b0);
      // R6: longest wait on a write burst, then read back
      run_xfer(1'b1, 1'b1, 8'h88, 4, 2'd3, 1'b0, 1'b0);
      run_xfer(1'b0, 1'b1, 8'h84, 4, 2'd0, 1'b0, 1'b0);
      // R7: refused write burst touches one word only
      run_xfer(1'b1, 1'b1, 8'hC8, 4, 2'd2, 1'b1, 1'b0);
      run_xfer(1'b0, 1'b1, 8'hC0, 4, 2'd0, 1'b0, 1'b0);
      // R9: start strobe during last ack
      run_xfer(1'b0, 1'b1, 8'h14, 3, 2'd0, 1'b0, 1'b1);
      run_xfer(1'b0, 1'b1, 8'h10, 4, 2'd0, 1'b0, 1'b0);

      for (int t = 0; t < 200; t++)
         run_xfer(1'($urandom), 1'($urandom), 8'($urandom), 1 + int'($urandom % 4),
                  2'($urandom), (($urandom % 4) == 0), (($urandom % 8) == 0));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule